// File: doc/BRIEF.md
# Streaming Debug Capture Controller

This block sits beside the logic under observation and looks at a bus of probe bits on every clock. A programmable trigger built from a masked AND term and a masked OR term starts a capture window. A separate qualification equation decides which cycles inside the window are actually recorded. Recorded samples go into a small output FIFO. A serial link that drains the FIFO into external trace memory is attached through a valid/ready handshake.

There are two capture modes. In streaming mode, samples are recorded until the window length is reached. When the FIFO is full, capture pauses and then resumes by itself, and the first word after the break carries a gap flag. In burst mode, a window is a chunk whose size is clamped to the FIFO depth. A chunk starts only when the FIFO already has room for all of it. Each window's first word carries a free-running cycle stamp, so the host can place qualified or interrupted captures in time. Software configures the block through eight write-only registers and controls it with arm and abort pulses. It reads progress from a status word.

Top module: `dbg_capture_ctrl`

## Requirements
- R1: Only probe bits set in the trigger-source register (address 0) can influence the trigger. A bit enabled in a term mask but not in the source register is ignored.
- R2: With match = ~(probe ^ value) (value at address 3), the AND term is true when every bit enabled in the AND mask (address 1) matches. It is true when no bit is enabled. The OR term is true when any bit enabled in the OR mask (address 2) matches. Control bits [3:2] at address 6 select 0 = AND, 1 = OR, 2 = AND or OR, 3 = AND and OR.
- R3: Control bit 1 at address 6 is the repeat flag. When a window completes without repeat, the state becomes DONE. With repeat, the state returns to ARMED and waits for the next trigger.
- R4: A cycle in the CAPTURING state is recorded only when every probe bit enabled in the qualification mask (address 4) equals the matching bit of the qualification value (address 5). A zero mask qualifies every cycle.
- R5: In streaming mode, a qualified sample that meets a full FIFO is dropped, and the state becomes PAUSED. One cycle after the FIFO level drops below the depth, the state returns to CAPTURING. Samples in the PAUSED state and in the resume cycle are not recorded.
- R6: The window length at address 7 is read as 1 when it is 0. In burst mode (control bit 0 = 1), a length above the FIFO depth is clamped to the depth.
- R7: A trigger seen in the ARMED state moves the controller to CAPTURING on the next edge. Recording starts in the following cycle, and the window ends after exactly the effective length of recorded samples.
- R8: In burst mode, a trigger (or a pending one) starts a window only when the FIFO's free entries are at least the effective length. Otherwise the controller stays ARMED with the pending flag set, until the room exists.
- R9: Each output word is {first, gap, stamp[15:0], sample[7:0]}. The first flag marks the first word of a window. In that word, stamp holds the free-running cycle count (the number of clock edges since reset) of the recording cycle. In every other word, stamp is 0.
- R10: The gap flag is set in the first word recorded after a PAUSED period, and in the first word of every window that follows an earlier window under repeat. It is clear in all other words.
- R11: Status is {state[2:0], pending, level[3:0]} with IDLE = 0, ARMED = 1, CAPTURING = 2, PAUSED = 3 and DONE = 4. An arm pulse moves IDLE or DONE to ARMED. An abort pulse returns the controller to IDLE from any state, and empties the FIFO.
- R12: Output words leave in recording order. While out_valid_o is high and out_ready_i is low, the word held on the output does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| probe_i | input | 8 | Probed internal signals, sampled every clock |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration register address |
| cfg_wdata_i | input | 8 | Configuration write data |
| arm_i | input | 1 | Arm pulse |
| abort_i | input | 1 | Abort pulse |
| out_valid_o | output | 1 | Output word available |
| out_ready_i | input | 1 | Downstream accepts the word |
| out_data_o | output | 26 | {first, gap, stamp, sample} |
| status_o | output | 8 | {state, pending, FIFO level} |

## Verification
The trigger select is swept exhaustively over all probe values, with a term mask bit that is not a trigger source. A design that let non-source bits through, or swapped the select codes, would start windows on the wrong patterns. The streaming test fills the FIFO on purpose and frees a single slot. A design that resumed a cycle early, kept the dropped sample or forgot the gap flag would show a wrong word order or flag. The burst tests check the clamp to depth and the pending start. A design that started a chunk without room would either overflow or emit the wrong words once draining frees the space.

// File: rtl/capture_pkg.sv
package capture_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ARMED  = 3'd1,
    ST_CAPT   = 3'd2,
    ST_PAUSED = 3'd3,
    ST_DONE   = 3'd4
  } cap_state_e;

  localparam logic [1:0] SEL_AND    = 2'd0;
  localparam logic [1:0] SEL_OR     = 2'd1;
  localparam logic [1:0] SEL_EITHER = 2'd2;
  localparam logic [1:0] SEL_BOTH   = 2'd3;

  typedef struct packed {
    logic [1:0] sel;
    logic       rpt;
    logic       burst;
  } cap_ctrl_t;
endpackage

// File: rtl/probe_match.sv
module probe_match #(
  parameter int W = 8
) (
  input  logic [W-1:0] probe_i,
  input  logic [W-1:0] src_i,
  input  logic [W-1:0] and_mask_i,
  input  logic [W-1:0] or_mask_i,
  input  logic [W-1:0] value_i,
  output logic         and_o,
  output logic         or_o
);
  logic [W-1:0] match, and_en, or_en;

  assign match  = ~(probe_i ^ value_i);
  assign and_en = and_mask_i & src_i;
  assign or_en  = or_mask_i & src_i;
  assign and_o  = &(match | ~and_en);
  assign or_o   = |(match & or_en);
endmodule

// File: rtl/sample_fifo.sv
module sample_fifo #(
  parameter int WIDTH = 26,
  parameter int DEPTH = 8,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVW = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             valid_o,
  output logic [LVW-1:0]   level_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_q, rd_q;
  logic [LVW-1:0]   level_q;
  logic             pop_ok;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign valid_o = (level_q != '0);
  assign pop_ok  = pop_i && valid_o;
  assign data_o  = mem_q[rd_q];
  assign level_o = level_q;

  always_ff @(posedge clk_i) begin
    if (push_i) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else if (clr_i) begin
      wr_q    <= '0;
      rd_q    <= '0;
      level_q <= '0;
    end else begin
      if (push_i) wr_q <= nxt(wr_q);
      if (pop_ok) rd_q <= nxt(rd_q);
      level_q <= level_q + LVW'(push_i) - LVW'(pop_ok);
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (int'(level_q) < DEPTH)); // R5
endmodule

// File: rtl/dbg_capture_ctrl.sv
module dbg_capture_ctrl
  import capture_pkg::*;
#(
  parameter int PW         = 8,
  parameter int FIFO_DEPTH = 8,
  parameter int CW         = 16,
  parameter int LW         = 8,
  localparam int LVW = $clog2(FIFO_DEPTH + 1),
  localparam int OW  = PW + CW + 2,
  localparam int SW  = LVW + 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [PW-1:0] probe_i,
  input  logic          cfg_we_i,
  input  logic [2:0]    cfg_addr_i,
  input  logic [PW-1:0] cfg_wdata_i,
  input  logic          arm_i,
  input  logic          abort_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [OW-1:0] out_data_o,
  output logic [SW-1:0] status_o
);
  logic [PW-1:0] src_q, and_q, or_q, tval_q, qmask_q, qval_q;
  cap_ctrl_t     ctrl_q;
  logic [LW-1:0] len_q, len_eff, cnt_q, cnt_d;
  logic [CW-1:0] cyc_q;
  cap_state_e    state_q, state_d;
  logic          pend_q, pend_d, gap_q, gap_d;
  logic          and_t, or_t, trig_hit, qual_hit, push, full, room_ok, first;
  logic [LVW-1:0] level;
  logic [OW-1:0]  word;

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= '0; and_q <= '0; or_q <= '0; tval_q <= '0;
      qmask_q <= '0; qval_q <= '0; ctrl_q <= '0; len_q <= '0;
    end else if (cfg_we_i) begin
      case (cfg_addr_i)
        3'd0: src_q   <= cfg_wdata_i;
        3'd1: and_q   <= cfg_wdata_i;
        3'd2: or_q    <= cfg_wdata_i;
        3'd3: tval_q  <= cfg_wdata_i;
        3'd4: qmask_q <= cfg_wdata_i;
        3'd5: qval_q  <= cfg_wdata_i;
        3'd6: ctrl_q  <= cfg_wdata_i[3:0];
        default: len_q <= cfg_wdata_i[LW-1:0];
      endcase
    end
  end

  probe_match #(.W(PW)) u_trig (
    .probe_i(probe_i), .src_i(src_q), .and_mask_i(and_q), .or_mask_i(or_q),
    .value_i(tval_q), .and_o(and_t), .or_o(or_t)
  );

  always_comb begin
    case (ctrl_q.sel)
      SEL_AND:    trig_hit = and_t;
      SEL_OR:     trig_hit = or_t;
      SEL_EITHER: trig_hit = and_t | or_t;
      default:    trig_hit = and_t & or_t;
    endcase
  end

  assign qual_hit = &(~(probe_i ^ qval_q) | ~qmask_q);

  always_comb begin
    len_eff = (len_q == '0) ? LW'(1) : len_q;
    if (ctrl_q.burst && int'(len_eff) > FIFO_DEPTH) len_eff = LW'(FIFO_DEPTH);
  end

  assign full    = (int'(level) == FIFO_DEPTH);
  assign room_ok = (FIFO_DEPTH - int'(level)) >= int'(len_eff);

  always_comb begin
    state_d = state_q;
    pend_d  = pend_q;
    gap_d   = gap_q;
    cnt_d   = cnt_q;
    push    = 1'b0;
    if (abort_i) begin
      state_d = ST_IDLE;
      pend_d  = 1'b0;
      gap_d   = 1'b0;
      cnt_d   = '0;
    end else begin
      case (state_q)
        ST_IDLE, ST_DONE: if (arm_i) begin
          state_d = ST_ARMED;
          gap_d   = 1'b0;
          cnt_d   = '0;
        end
        ST_ARMED: if (trig_hit || pend_q) begin
          if (ctrl_q.burst && !room_ok) pend_d = 1'b1;
          else begin
            pend_d  = 1'b0;
            state_d = ST_CAPT;
            cnt_d   = '0;
          end
        end
        ST_CAPT: if (qual_hit) begin
          if (full) begin
            state_d = ST_PAUSED;
            gap_d   = 1'b1;
          end else begin
            push  = 1'b1;
            gap_d = 1'b0;
            if ({1'b0, cnt_q} + 1'b1 == {1'b0, len_eff}) begin
              cnt_d   = '0;
              state_d = ctrl_q.rpt ? ST_ARMED : ST_DONE;
              gap_d   = ctrl_q.rpt;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_PAUSED: if (!full) state_d = ST_CAPT;
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pend_q  <= 1'b0;
      gap_q   <= 1'b0;
      cnt_q   <= '0;
      cyc_q   <= '0;
    end else begin
      state_q <= state_d;
      pend_q  <= pend_d;
      gap_q   <= gap_d;
      cnt_q   <= cnt_d;
      cyc_q   <= cyc_q + 1'b1;
    end
  end

  assign first = (cnt_q == '0);
  assign word  = {first, gap_q, first ? cyc_q : CW'(0), probe_i};

  sample_fifo #(.WIDTH(OW), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(abort_i), .push_i(push),
    .data_i(word), .pop_i(out_ready_i), .data_o(out_data_o),
    .valid_o(out_valid_o), .level_o(level)
  );

  assign status_o = {state_q, pend_q, level};

  AST_ABORT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (state_q == ST_IDLE) && !out_valid_o); // R11
  AST_ARM_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && arm_i && !abort_i) |=> state_q == ST_ARMED); // R11
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i && !abort_i) |=> out_valid_o && $stable(out_data_o)); // R12
  AST_PAUSE_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PAUSED) |-> gap_q); // R10
  AST_PEND_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (state_q == ST_ARMED)); // R8
endmodule

// File: tb/test_dbg_capture_ctrl.sv
`timescale 1ns/1ps
module test_dbg_capture_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  probe = '0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic        arm = 1'b0, abort = 1'b0, ready = 1'b0;
  logic        out_valid;
  logic [25:0] dout;
  logic [7:0]  status;
  int nchk = 0, nfail = 0;
  bit fin = 0;
  logic [15:0] bcyc = '0;
  logic [15:0] st0, st1;

  always #2.5 clk = ~clk;
  always @(posedge clk) if (rst_n) bcyc <= bcyc + 1'b1;

  dbg_capture_ctrl i_dbg_capture_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .probe_i(probe), .cfg_we_i(we),
    .cfg_addr_i(addr), .cfg_wdata_i(wdata), .arm_i(arm), .abort_i(abort),
    .out_valid_o(out_valid), .out_ready_i(ready), .out_data_o(dout),
    .status_o(status)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cfg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic abort_seq();
    @(negedge clk); abort = 1'b1;
    @(negedge clk); abort = 1'b0;
  endtask

  task automatic arm_then(input logic [7:0] p);
    @(negedge clk); arm = 1'b1;
    @(negedge clk); arm = 1'b0; probe = p;
  endtask

  task automatic drv(input logic [7:0] p);
    @(negedge clk); probe = p;
  endtask

  task automatic chk_stat(input string req, input int s, input int pd, input int lv);
    chk(req, status[7:5], s);
    chk(req, status[4], pd);
    chk(req, status[3:0], lv);
  endtask

  task automatic pop_chk(input string req, input logic [7:0] s, input bit f,
                         input bit g, input logic [15:0] stamp);
    chk(req, out_valid, 1);
    chk(req, dout[7:0], s);
    chk(req, dout[25], f);
    chk(req, dout[24], g);
    chk(req, dout[23:8], f ? stamp : 16'h0);
    ready = 1'b1;
    @(negedge clk); ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!fin) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [25:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset status", status, 0);
    chk("R12 reset valid", out_valid, 0);

    // R1/R2 exhaustive trigger sweep; bit4 is in the AND mask but not a source
    cfg(0, 8'h0F); cfg(1, 8'h13); cfg(2, 8'h0C); cfg(3, 8'h05);
    cfg(4, 8'h00); cfg(7, 8'd1);
    for (int sel = 0; sel < 4; sel++) begin
      cfg(6, 8'(sel << 2));
      for (int p = 0; p < 256; p++) begin
        bit a_t, o_t, hit;
        a_t = (p[0] == 1'b1) && (p[1] == 1'b0);
        o_t = (p[2] == 1'b1) || (p[3] == 1'b0);
        case (sel)
          0: hit = a_t;
          1: hit = o_t;
          2: hit = a_t | o_t;
          default: hit = a_t & o_t;
        endcase
        abort_seq();
        arm_then(8'(p));
        @(negedge clk);
        chk("R1/R2 trigger sweep", status[7:5], hit ? 2 : 1);
        probe = 8'h00;
      end
    end

    // R4/R7/R9 streaming single shot with qualification
    cfg(0, 8'h01); cfg(1, 8'h01); cfg(2, 8'h00); cfg(3, 8'h01);
    cfg(4, 8'h80); cfg(5, 8'h80); cfg(6, 8'h00); cfg(7, 8'd3);
    abort_seq();
    arm_then(8'h01);
    drv(8'h00); drv(8'h81); st0 = bcyc;
    drv(8'h02); drv(8'h82); drv(8'h83); drv(8'h84);
    @(negedge clk);
    chk_stat("R7 window of three", 4, 0, 3);
    held = dout;
    repeat (2) @(negedge clk);
    chk("R12 word held", dout, held);
    pop_chk("R9 first word stamp", 8'h81, 1, 0, st0);
    pop_chk("R4 qualified only", 8'h82, 0, 0, 0);
    pop_chk("R4 qualified only", 8'h83, 0, 0, 0);
    chk("R4 nothing extra", out_valid, 0);

    // R3/R10 repeat mode
    cfg(4, 8'h00); cfg(6, 8'h02); cfg(7, 8'd2);
    abort_seq();
    arm_then(8'h01);
    drv(8'h10); st0 = bcyc;
    drv(8'h11); drv(8'h20); drv(8'h21);
    drv(8'h30); st1 = bcyc;
    drv(8'h32);
    @(negedge clk);
    chk_stat("R3 repeat rearms", 1, 0, 4);
    probe = 8'h00;
    pop_chk("R10 first window no gap", 8'h10, 1, 0, st0);
    pop_chk("R3 second sample", 8'h11, 0, 0, 0);
    pop_chk("R10 later window gap", 8'h30, 1, 1, st1);
    pop_chk("R3 last sample", 8'h32, 0, 0, 0);

    // R5/R10 streaming backpressure
    cfg(4, 8'h40); cfg(5, 8'h40); cfg(6, 8'h00); cfg(7, 8'd12);
    abort_seq();
    arm_then(8'h01);
    for (int i = 0; i < 8; i++) begin
      drv(8'(8'h40 + i));
      if (i == 0) st0 = bcyc;
    end
    drv(8'h48);
    @(negedge clk);
    chk_stat("R5 paused when full", 3, 0, 8);
    probe = 8'h49;
    pop_chk("R12 order while paused", 8'h40, 1, 0, st0);
    probe = 8'h4A;
    drv(8'h4B); drv(8'h4C); drv(8'h00);
    chk_stat("R5 paused again", 3, 0, 8);
    for (int i = 1; i < 8; i++) pop_chk("R5 contiguous before pause", 8'(8'h40 + i), 0, 0, 0);
    pop_chk("R10 gap after resume", 8'h4B, 0, 1, 0);
    chk("R5 drop during pause", out_valid, 0);
    chk("R5 resumed", status[7:5], 2);

    // R6 burst clamp to depth and zero length
    cfg(4, 8'h00); cfg(6, 8'h01); cfg(7, 8'd20);
    abort_seq();
    arm_then(8'h01);
    for (int i = 0; i < 12; i++) drv(8'(8'h50 + i));
    @(negedge clk);
    chk_stat("R6 burst clamped to depth", 4, 0, 8);
    cfg(7, 8'd0);
    abort_seq();
    arm_then(8'h01);
    drv(8'h55); st0 = bcyc;
    drv(8'h56);
    @(negedge clk);
    chk_stat("R6 zero length is one", 4, 0, 1);
    pop_chk("R6 single sample", 8'h55, 1, 0, st0);

    // R8 burst pending until room
    cfg(6, 8'h03); cfg(7, 8'd5);
    abort_seq();
    arm_then(8'h01);
    for (int i = 0; i < 5; i++) begin
      drv(8'(8'h60 + i));
      if (i == 0) st0 = bcyc;
    end
    drv(8'h01); drv(8'h00);
    chk_stat("R8 pending without room", 1, 1, 5);
    drv(8'h00);
    chk_stat("R8 still pending", 1, 1, 5);
    pop_chk("R8 burst word", 8'h60, 1, 0, st0);
    pop_chk("R8 burst word", 8'h61, 0, 0, 0);
    @(negedge clk);
    chk_stat("R8 starts once room", 2, 0, 3);
    probe = 8'h70; st1 = bcyc;
    for (int i = 1; i < 5; i++) drv(8'(8'h70 + i));
    @(negedge clk);
    chk_stat("R8 second burst done", 1, 0, 8);
    probe = 8'h00;
    for (int i = 2; i < 5; i++) pop_chk("R8 first burst tail", 8'(8'h60 + i), 0, 0, 0);
    pop_chk("R10 second burst gap", 8'h70, 1, 1, st1);
    for (int i = 1; i < 5; i++) pop_chk("R8 second burst", 8'(8'h70 + i), 0, 0, 0);

    // R11 abort from capture flushes
    cfg(6, 8'h00); cfg(7, 8'd12);
    abort_seq();
    arm_then(8'h01);
    drv(8'h90); drv(8'h91);
    @(negedge clk);
    chk_stat("R11 capturing", 2, 0, 2);
    abort = 1'b1;
    @(negedge clk); abort = 1'b0;
    chk_stat("R11 abort to idle", 0, 0, 0);
    chk("R11 abort flushes", out_valid, 0);

    fin = 1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule